// File: doc/BRIEF.md
# Virtual Function Reset Tracker

This block keeps one status flag for each virtual function of an endpoint. When the host starts a function-level reset of a virtual function, the flag for that function goes high. It stays high until the user logic finishes the reset work and reports it. The user reports completion by pulsing a done strobe while presenting the number of the finished function.

The flags leave the block as a single wide vector, one bit per function. User logic polls that vector to see which functions still have reset work outstanding. Two things happen elsewhere: decoding the configuration write that starts a reset, and doing the reset itself. The block only stores the in-process state and clears it.

Top module: `vfr_tracker`

## Requirements
- R1: A synchronous active-high reset clears every bit of the in-process vector. The vector reads all zeros on the cycle after the reset is sampled, even if bits were set beforehand.
- R2: When `req_vld` is high with `req_idx` below `NUM_FN`, bit `req_idx` of `vfr_busy` is high from the next clock edge on. Bit `k` of the vector belongs to function number `k`.
- R3: A set bit stays high on every cycle without a matching completion, including idle cycles and cycles that complete other functions.
- R4: When `done_vld` is high with `done_idx` below `NUM_FN`, only bit `done_idx` is cleared at the next edge. Every other bit keeps its value.
- R5: If a request and a completion name the same function in the same cycle, the bit is high after the edge, because the set wins.
- R6: A request whose index is `NUM_FN` or larger changes no bit of the vector. With the defaults, that means indices 252 to 255.
- R7: A completion whose index is `NUM_FN` or larger changes no bit of the vector.
- R8: A completion that names a function whose bit is already low has no effect on any bit.
- R9: A request and a completion that name different functions in the same cycle both take effect at the same edge.
- R10: While `req_vld` or `done_vld` is low, the matching index input has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | 1 | Single-cycle strobe: the host started a reset of one function |
| req_idx | input | 8 | Function number for the request |
| done_vld | input | 1 | Single-cycle strobe: user reports a reset complete |
| done_idx | input | 8 | Function number for the completion |
| vfr_busy | output | NUM_FN (252) | In-process flags, bit k for function k |

## Verification
The bench builds the tracker with its default of 252 functions and an 8-bit index. With those values the four encodable but unused indices, 252 to 255, can be driven for both requests and completions. The topmost valid bit, 251, can be set and cleared next to them. The bench also drives same-cycle request/completion pairs, on one function and on two different functions. That exercises the set-wins priority and the parallel update, and a reset issued while many flags are high is checked to clear them all.

// File: rtl/vfr_pkg.sv
package vfr_pkg;

    localparam int VFR_MAX_FN = 252;
    localparam int VFR_IDX_W  = 8;

    // An event on one function: qualified strobe plus its number.
    typedef struct packed {
        logic                 hit;
        logic [VFR_IDX_W-1:0] idx;
    } fn_evt_t;

    function automatic logic idx_in_range(input logic [VFR_IDX_W-1:0] idx, input int n);
        return int'(idx) < n;
    endfunction

    function automatic fn_evt_t make_evt(input logic vld,
                                         input logic [VFR_IDX_W-1:0] idx,
                                         input int n);
        fn_evt_t e;
        e.hit = vld && idx_in_range(idx, n);
        e.idx = idx;
        return e;
    endfunction

endpackage

// File: rtl/vfr_decode.sv
module vfr_decode
    import vfr_pkg::*;
#(
    parameter int NUM_FN = VFR_MAX_FN
) (
    input  fn_evt_t           evt,
    output logic [NUM_FN-1:0] mask
);

    // One comparator per function; an out-of-range index matches none.
    for (genvar i = 0; i < NUM_FN; i++) begin : g_bit
        assign mask[i] = evt.hit && (evt.idx == VFR_IDX_W'(i));
    end

endmodule

// File: rtl/vfr_flag_bank.sv
module vfr_flag_bank #(
    parameter int NUM_FN = 252
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_FN-1:0] set_m,
    input  logic [NUM_FN-1:0] clr_m,
    output logic [NUM_FN-1:0] q
);

    for (genvar i = 0; i < NUM_FN; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                q[i] <= 1'b0;
            else if (set_m[i])
                q[i] <= 1'b1;   // set outranks clear
            else if (clr_m[i])
                q[i] <= 1'b0;
        end
    end

endmodule

// File: rtl/vfr_tracker.sv
module vfr_tracker
    import vfr_pkg::*;
#(
    parameter int NUM_FN = VFR_MAX_FN
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_vld,
    input  logic [VFR_IDX_W-1:0] req_idx,
    input  logic                 done_vld,
    input  logic [VFR_IDX_W-1:0] done_idx,
    output logic [NUM_FN-1:0]    vfr_busy
);

    fn_evt_t           req_evt;
    fn_evt_t           done_evt;
    logic [NUM_FN-1:0] set_m;
    logic [NUM_FN-1:0] clr_m;

    always_comb begin
        req_evt  = make_evt(req_vld,  req_idx,  NUM_FN);
        done_evt = make_evt(done_vld, done_idx, NUM_FN);
    end

    vfr_decode #(.NUM_FN(NUM_FN)) u_dec_req (
        .evt  (req_evt),
        .mask (set_m)
    );

    vfr_decode #(.NUM_FN(NUM_FN)) u_dec_done (
        .evt  (done_evt),
        .mask (clr_m)
    );

    vfr_flag_bank #(.NUM_FN(NUM_FN)) u_bank (
        .clk   (clk),
        .rst   (rst),
        .set_m (set_m),
        .clr_m (clr_m),
        .q     (vfr_busy)
    );

endmodule

// File: rtl/vfr_tracker_chk.sv
module vfr_tracker_chk
    import vfr_pkg::*;
#(
    parameter int NUM_FN = VFR_MAX_FN
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 req_vld,
    input logic [VFR_IDX_W-1:0] req_idx,
    input logic                 done_vld,
    input logic [VFR_IDX_W-1:0] done_idx,
    input logic [NUM_FN-1:0]    vfr_busy
);

    localparam logic [NUM_FN-1:0] ONE = NUM_FN'(1);

    logic [NUM_FN-1:0] rq_m;
    logic [NUM_FN-1:0] dn_m;

    assign rq_m = (req_vld  && int'(req_idx)  < NUM_FN) ? (ONE << req_idx)  : '0;
    assign dn_m = (done_vld && int'(done_idx) < NUM_FN) ? (ONE << done_idx) : '0;

    AST_RST_CLEAR: assert property (@(posedge clk) rst |=> vfr_busy == '0); // R1

    AST_SET_TAKES: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (vfr_busy & $past(rq_m)) == $past(rq_m)); // R2

    AST_HOLD: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (vfr_busy & $past(vfr_busy & ~dn_m)) == $past(vfr_busy & ~dn_m)); // R3

    AST_CLEAR: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (vfr_busy & $past(dn_m & ~rq_m)) == '0); // R4

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (vfr_busy & ~$past(vfr_busy | rq_m)) == '0); // R6

endmodule

bind vfr_tracker vfr_tracker_chk #(.NUM_FN(NUM_FN)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_vld  (req_vld),
    .req_idx  (req_idx),
    .done_vld (done_vld),
    .done_idx (done_idx),
    .vfr_busy (vfr_busy)
);

// File: tb/vfr_tracker_tb.sv
module vfr_tracker_tb;

    localparam int N = 252;

    typedef struct {
        logic [N-1:0] vec;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_vld = 1'b0;
    logic [7:0]   req_idx = '0;
    logic         done_vld = 1'b0;
    logic [7:0]   done_idx = '0;
    logic [N-1:0] vfr_busy;

    logic [N-1:0] model = '0;
    exp_t         sb_q[$];
    int           checks = 0;
    int           errors = 0;
    bit           finished = 1'b0;

    always #5 clk = ~clk;

    vfr_tracker #(.NUM_FN(N)) u_dut (
        .clk      (clk),
        .rst      (rst),
        .req_vld  (req_vld),
        .req_idx  (req_idx),
        .done_vld (done_vld),
        .done_idx (done_idx),
        .vfr_busy (vfr_busy)
    );

    // Driver: one operation per cycle, expected vector queued after the edge.
    task automatic op(input logic rv, input int ri, input logic dv, input int di,
                      input logic r, input string tag);
        logic [N-1:0] nxt;
        @(negedge clk);
        rst      = r;
        req_vld  = rv;
        req_idx  = 8'(ri);
        done_vld = dv;
        done_idx = 8'(di);
        nxt = model;
        if (r) nxt = '0;
        else begin
            if (dv && di < N) nxt[di] = 1'b0;
            if (rv && ri < N) nxt[ri] = 1'b1;
        end
        @(posedge clk);
        model = nxt;
        sb_q.push_back('{vec: nxt, tag: tag});
    endtask

    // Monitor: compares at the falling edge after each update.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (vfr_busy !== e.vec) begin
                errors++;
                $display("FAIL %s actual=%h expected=%h", e.tag, vfr_busy, e.vec);
            end
        end
    end

    initial begin
        op(0, 0, 0, 0, 1, "R1 reset state");
        op(1, 0, 0, 0, 0, "R2 set fn 0");
        op(1, 251, 0, 0, 0, "R2 set top fn 251");
        op(1, 100, 0, 0, 0, "R2 set fn 100");
        op(0, 0, 0, 0, 0, "R3 hold idle");
        op(0, 0, 0, 0, 0, "R3 hold idle again");
        op(0, 0, 1, 100, 0, "R4 clear fn 100 only");
        op(0, 0, 1, 5, 0, "R8 done on low bit");
        op(1, 7, 1, 7, 0, "R5 set wins same fn");
        op(0, 0, 0, 0, 0, "R5 fn 7 still set");
        op(1, 252, 0, 0, 0, "R6 request idx 252 ignored");
        op(1, 255, 0, 0, 0, "R6 request idx 255 ignored");
        op(0, 0, 1, 252, 0, "R7 done idx 252 ignored");
        op(0, 0, 1, 255, 0, "R7 done idx 255 ignored");
        op(1, 20, 1, 0, 0, "R9 set 20 clear 0 together");
        op(0, 3, 0, 251, 0, "R10 strobes low");
        op(0, 0, 1, 251, 0, "R4 clear top fn 251");
        op(0, 0, 1, 7, 0, "R3 others held while fn 7 clears");
        for (int i = 30; i < 40; i++) op(1, i, 0, 0, 0, "R2 burst set");
        op(1, 40, 0, 0, 1, "R1 reset with bits set");
        op(0, 0, 0, 0, 0, "R1 stays clear");
        @(negedge clk);
        @(negedge clk);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule